// File: doc/BRIEF.md
# Level-Sensitive Interrupt Combiner with APB Register Access

This block gathers up to 64 level-sensitive interrupt request lines and folds them into a single request toward a parent interrupt controller. Each line has its own admit control (enable) and its own suppress control (mask). A line counts as pending while it is asserted, enabled and not masked. Software reads the pending set as two 32-bit words and services each set bit in turn.

The number of lines is a build parameter from 2 to 64. Control bits for lines that are not built have no storage and always read as zero. Software can therefore find the line count by writing all ones to the enable words and reading them back. Register access uses APB with zero wait states and no error responses. Read data is captured at the end of the setup phase, so a status read shows the pending set as it stood in the setup cycle.

Top module: `apb_irq_combiner`

## Requirements
- R1: While `rst` is high, at the next rising edge all enable and mask bits clear, `irq_out` goes low and `prdata` goes to 0.
- R2: The enable words sit at byte offset 0x00 (lines 0 to 31) and 0x04 (lines 32 to 63). Bit k of a word is line 32*word+k. A write takes effect at the clock edge that ends the access phase, and a later read returns the stored value.
- R3: The mask words sit at byte offset 0x08 (lines 0 to 31) and 0x0C (lines 32 to 63), with the same bit order. A 1 suppresses the line and a 0 lets it through.
- R4: The pending words sit at byte offset 0x30 (lines 0 to 31) and 0x34 (lines 32 to 63). Each bit reads as input AND enable AND NOT mask, sampled in the setup cycle of the read.
- R5: Enable and mask bits at or above NUM_SRC read as 0 even after all ones are written. When NUM_SRC is 32 or less, the whole of the 0x04, 0x0C and 0x34 words reads as 0.
- R6: `irq_out` is the OR of all pending bits, registered. It follows the inputs one clock later and stays high as long as any pending line holds its level.
- R7: Writes to 0x30 or 0x34 change no enable or mask bit.
- R8: Reads from any other offset return 0, and writes to them change nothing. `pready` is always 1 and `pslverr` is always 0.
- R9: `prdata` changes only at the edge that ends a read setup phase. It holds its value through the access phase and the idle cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase marker |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, registered |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Always 0 |
| irq_src | input | NUM_SRC | Level-sensitive interrupt request lines |
| irq_out | output | 1 | Combined interrupt request, registered |

## Verification
The bound checker watches these on every cycle:
- `irq_out` is never raised without some input asserted the cycle before.
- Any admitted, unmasked, asserted line raises `irq_out` one cycle later.
- Writes to the pending words leave the control bits untouched.
- `prdata` moves only after a read setup phase.
- Outputs are quiet after reset.

Other behaviour needs the bench's scenarios. These are the readback of enable and mask in both words, and the zero readback of bits that are not built. They also include the decode of unmapped offsets and the pending words under different input patterns. A second, smaller instance shows that a build of 32 or fewer lines reads the high words as zero.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned MAX_SRC = 64;
  localparam int unsigned OFS_W   = 8;

  localparam logic [OFS_W-1:0] OFS_EN_LO   = 8'h00;
  localparam logic [OFS_W-1:0] OFS_EN_HI   = 8'h04;
  localparam logic [OFS_W-1:0] OFS_MASK_LO = 8'h08;
  localparam logic [OFS_W-1:0] OFS_MASK_HI = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_STAT_LO = 8'h30;
  localparam logic [OFS_W-1:0] OFS_STAT_HI = 8'h34;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_EN,
    SEL_MASK,
    SEL_STAT
  } reg_sel_t;

  typedef struct packed {
    reg_sel_t sel;
    logic     hi;
  } reg_dec_t;

  function automatic reg_dec_t decode_ofs(input logic [OFS_W-1:0] ofs);
    reg_dec_t d;
    d.sel = SEL_NONE;
    d.hi  = 1'b0;
    case (ofs)
      OFS_EN_LO:   d.sel = SEL_EN;
      OFS_EN_HI:   begin d.sel = SEL_EN;   d.hi = 1'b1; end
      OFS_MASK_LO: d.sel = SEL_MASK;
      OFS_MASK_HI: begin d.sel = SEL_MASK; d.hi = 1'b1; end
      OFS_STAT_LO: d.sel = SEL_STAT;
      OFS_STAT_HI: begin d.sel = SEL_STAT; d.hi = 1'b1; end
      default:     d.sel = SEL_NONE;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/irqc_apb_port.sv
module irqc_apb_port
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              wr_stb,
  output logic              rd_stb,
  output reg_dec_t          dec
);

  logic [OFS_W-1:0] ofs;
  logic             upper_zero;

  generate
    if (ADDR_W > OFS_W) begin : g_wide
      assign ofs        = paddr[OFS_W-1:0];
      assign upper_zero = (paddr[ADDR_W-1:OFS_W] == '0);
    end else begin : g_narrow
      assign ofs        = OFS_W'(paddr);
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    dec = decode_ofs(ofs);
    if (!upper_zero) begin
      dec.sel = SEL_NONE;
      dec.hi  = 1'b0;
    end
  end

  // Writes commit in the access phase; reads are captured in the setup phase.
  assign wr_stb = psel & penable & pwrite;
  assign rd_stb = psel & ~penable & ~pwrite;

endmodule

// File: rtl/irqc_src_regs.sv
module irqc_src_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  reg_dec_t           dec,
  input  logic [WORD_W-1:0]  pwdata,
  output logic [MAX_SRC-1:0] en_q,
  output logic [MAX_SRC-1:0] mask_q
);

  logic wr_en_lo, wr_en_hi, wr_mask_lo, wr_mask_hi;

  assign wr_en_lo   = wr_stb && dec.sel == SEL_EN   && !dec.hi;
  assign wr_en_hi   = wr_stb && dec.sel == SEL_EN   &&  dec.hi;
  assign wr_mask_lo = wr_stb && dec.sel == SEL_MASK && !dec.hi;
  assign wr_mask_hi = wr_stb && dec.sel == SEL_MASK &&  dec.hi;

  for (genvar g = 0; g < MAX_SRC; g++) begin : g_bit
    localparam int unsigned BIT = g % WORD_W;
    localparam bit          HI  = (g >= WORD_W);
    if (g < NUM_SRC) begin : g_store
      logic wr_e, wr_m;
      assign wr_e = HI ? wr_en_hi   : wr_en_lo;
      assign wr_m = HI ? wr_mask_hi : wr_mask_lo;
      always_ff @(posedge clk) begin
        if (rst) begin
          en_q[g]   <= 1'b0;
          mask_q[g] <= 1'b0;
        end else begin
          if (wr_e) en_q[g]   <= pwdata[BIT];
          if (wr_m) mask_q[g] <= pwdata[BIT];
        end
      end
    end else begin : g_absent
      assign en_q[g]   = 1'b0;
      assign mask_q[g] = 1'b0;
    end
  end

endmodule

// File: rtl/irqc_combine.sv
module irqc_combine
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [MAX_SRC-1:0] en_q,
  input  logic [MAX_SRC-1:0] mask_q,
  output logic [MAX_SRC-1:0] pend,
  output logic               irq_out
);

  for (genvar g = 0; g < MAX_SRC; g++) begin : g_pend
    if (g < NUM_SRC) begin : g_live
      assign pend[g] = irq_src[g] & en_q[g] & ~mask_q[g];
    end else begin : g_dead
      assign pend[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |pend;
  end

endmodule

// File: rtl/apb_irq_combiner.sv
module apb_irq_combiner
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic               irq_out
);

  logic               wr_stb, rd_stb;
  reg_dec_t           dec;
  logic [MAX_SRC-1:0] en_q, mask_q, pend;
  logic [WORD_W-1:0]  rd_word;

  irqc_apb_port #(.ADDR_W(ADDR_W)) u_port (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .dec(dec)
  );

  irqc_src_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .dec(dec), .pwdata(pwdata),
    .en_q(en_q), .mask_q(mask_q)
  );

  irqc_combine #(.NUM_SRC(NUM_SRC)) u_comb (
    .clk(clk), .rst(rst), .irq_src(irq_src), .en_q(en_q), .mask_q(mask_q),
    .pend(pend), .irq_out(irq_out)
  );

  always_comb begin
    case (dec.sel)
      SEL_EN:   rd_word = dec.hi ? en_q[MAX_SRC-1:WORD_W]   : en_q[WORD_W-1:0];
      SEL_MASK: rd_word = dec.hi ? mask_q[MAX_SRC-1:WORD_W] : mask_q[WORD_W-1:0];
      SEL_STAT: rd_word = dec.hi ? pend[MAX_SRC-1:WORD_W]   : pend[WORD_W-1:0];
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         prdata <= '0;
    else if (rd_stb) prdata <= rd_word;
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [ADDR_W-1:0]  paddr,
  input logic [31:0]        prdata,
  input logic [NUM_SRC-1:0] irq_src,
  input logic               irq_out,
  input logic [63:0]        en_q,
  input logic [63:0]        mask_q
);

  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: outputs quiet after a reset edge
  always @(negedge clk) begin
    if (rst_d) begin
      a_r1_reset_quiet: assert (!irq_out && prdata == 32'd0);
    end
  end

  a_r6_irq_needs_src: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|irq_src));

  a_r6_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (|(irq_src & en_q[NUM_SRC-1:0] & ~mask_q[NUM_SRC-1:0])) |=> irq_out);

  a_r7_stat_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pwrite &&
     (paddr == ADDR_W'(8'h30) || paddr == ADDR_W'(8'h34)))
    |=> ($stable(en_q) && $stable(mask_q)));

  a_r9_prdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(psel && !penable && !pwrite) |=> $stable(prdata));

endmodule

bind apb_irq_combiner irqc_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .irq_src(irq_src), .irq_out(irq_out),
  .en_q(en_q), .mask_q(mask_q)
);

// File: tb/tb_apb_irq_combiner.sv
`timescale 1ns/1ps
module tb_apb_irq_combiner;

  localparam int N  = 40;
  localparam int NS = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [N-1:0] src = '0;
  logic [31:0] prdata, prdata_s;
  logic        pready, pslverr, irq_out, pready_s, pslverr_s, irq_s;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  apb_irq_combiner #(.NUM_SRC(N), .ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq_src(src), .irq_out(irq_out)
  );

  apb_irq_combiner #(.NUM_SRC(NS), .ADDR_W(8)) dut_small (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_s), .pready(pready_s),
    .pslverr(pslverr_s), .irq_src(src[NS-1:0]), .irq_out(irq_s)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_en = '0, m_mask = '0, impl = '0;
  logic        exp_irq = 1'b0;
  logic [31:0] exp_prd = '0;

  initial for (int i = 0; i < N; i++) impl[i] = 1'b1;

  function automatic logic [31:0] ref_read(input logic [7:0] a);
    logic [63:0] p;
    p = 64'(src) & m_en & ~m_mask;
    case (a)
      8'h00: return m_en[31:0];
      8'h04: return m_en[63:32];
      8'h08: return m_mask[31:0];
      8'h0C: return m_mask[63:32];
      8'h30: return p[31:0];
      8'h34: return p[63:32];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = '0; m_mask = '0; exp_irq = 1'b0; exp_prd = '0;
    end else begin
      exp_irq = |(64'(src) & m_en & ~m_mask);
      if (psel && !penable && !pwrite) exp_prd = ref_read(paddr);
      if (psel && penable && pwrite) begin
        case (paddr)
          8'h00: m_en[31:0]    = pwdata & impl[31:0];
          8'h04: m_en[63:32]   = pwdata & impl[63:32];
          8'h08: m_mask[31:0]  = pwdata & impl[31:0];
          8'h0C: m_mask[63:32] = pwdata & impl[63:32];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model (R6, R8, R9)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R6 irq_out", {31'd0, irq_out}, {31'd0, exp_irq});
      check("R9 prdata", prdata, exp_prd);
      check("R8 pready/pslverr", {30'd0, pready, pslverr}, 32'd2);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] ds);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata; ds = prdata_s;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d, ds;
    rd(a, d, ds);
    check(tag, d, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ds;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq_out at reset", {31'd0, irq_out}, 32'd0);
    check("R1 prdata at reset", prdata, 32'd0);
    rst = 0;
    rd_chk("R1 enable lo", 8'h00, 32'd0);
    rd_chk("R1 mask lo", 8'h08, 32'd0);

    // R2 / R5: enable words
    wr(8'h00, 32'hA5A5_0F0F);
    rd_chk("R2 enable lo readback", 8'h00, 32'hA5A5_0F0F);
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk("R5 enable hi unbuilt bits", 8'h04, 32'h0000_00FF);
    rd(8'h04, d, ds);
    check("R5 small build enable hi", ds, 32'd0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d, ds);
    check("R5 small build enable lo", ds, 32'h000F_FFFF);

    // R3: mask words
    wr(8'h08, 32'h0000_FFFF);
    rd_chk("R3 mask lo readback", 8'h08, 32'h0000_FFFF);
    wr(8'h0C, 32'hFFFF_FF0F);
    rd_chk("R3/R5 mask hi readback", 8'h0C, 32'h0000_000F);
    rd(8'h0C, d, ds);
    check("R5 small build mask hi", ds, 32'd0);

    // R4 / R6: pending words under input patterns
    src = 40'hF0_0001_0001;
    rd_chk("R4 status lo (masked low half)", 8'h30, 32'h0001_0000);
    rd_chk("R4 status hi", 8'h34, 32'h0000_00F0);
    check("R6 irq high", {31'd0, irq_out}, 32'd1);
    rd(8'h34, d, ds);
    check("R5 small build status hi", ds, 32'd0);
    src = 40'h0F_0000_FFFF;        // all masked
    @(negedge clk); @(negedge clk);
    check("R6 irq low when all masked", {31'd0, irq_out}, 32'd0);
    rd_chk("R4 status lo all masked", 8'h30, 32'd0);
    wr(8'h08, 32'h0);
    rd_chk("R4 status lo unmasked", 8'h30, 32'h0000_FFFF);
    repeat (5) begin
      @(negedge clk);
      check("R6 level held", {31'd0, irq_out}, 32'd1);
    end
    src = '0;
    @(negedge clk);
    check("R6 drops one cycle after input", {31'd0, irq_out}, 32'd0);

    // R7: writes to pending words ignored
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h0);
    rd_chk("R7 enable lo kept", 8'h00, 32'hFFFF_FFFF);
    rd_chk("R7 mask hi kept", 8'h0C, 32'h0000_000F);

    // R8: unmapped offsets
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R8 unmapped 0x10", 8'h10, 32'd0);
    rd_chk("R8 unmapped 0x38", 8'h38, 32'd0);
    rd_chk("R8 enable unchanged", 8'h00, 32'hFFFF_FFFF);

    // R9: prdata holds through idle cycles
    rd(8'h00, d, ds);
    repeat (4) @(negedge clk);
    check("R9 prdata held", prdata, 32'hFFFF_FFFF);

    // random traffic, checked per clock against the model
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 7))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'h30; 5: a = 8'h34; 6: a = 8'h20; default: a = 8'h00;
      endcase
      src = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 1) wr(a, $urandom);
      else rd(a, d, ds);
    end

    // R1: reset mid-operation clears control state
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk);
    check("R1 irq_out after reset", {31'd0, irq_out}, 32'd0);
    check("R1 prdata after reset", prdata, 32'd0);
    rst = 0;
    rd_chk("R1 enable lo cleared", 8'h00, 32'd0);
    rd_chk("R1 mask hi cleared", 8'h0C, 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule